// File: doc/BRIEF.md
# Dual-Slope Conversion Cycle Sequencer

This block produces the digital timing for a dual-slope integrating analog-to-digital converter. A free-running oscillator clock is halved into count ticks. Every conversion passes through four phases: offset nulling, a fixed-length integration of the input, a de-integration against a reference of the opposite polarity, and a settling phase that pads the cycle to a constant length. The integrator, the reference switches and the comparator lie outside the block. The block sees only the comparator output, which is high while the integrator output sits above zero.

The de-integration length is counted in packed BCD and is the conversion result. The result, the input sign and an over-range flag are latched when de-integration ends. A one-clock valid pulse follows when the cycle wraps. A range pin selects a short integration window, which makes the full-scale input ten times larger. The comparator sample taken at the last integration tick decides the input sign and the reference polarity.

Top module: `dualSlopeSequencer`

## Requirements
- R1: One count tick spans two clock cycles; the first tick after reset release falls on the second rising edge, and every phase boundary falls on a tick.
- R2: The offset-nulling phase (`phAutoZero`) lasts AZ_COUNTS counts, i.e. 2·AZ_COUNTS clocks.
- R3: The integration phase (`phIntegrate`) lasts INT_LONG counts when `rangeSel` was low at its start, and INT_SHORT counts when it was high; `rangeSel` is sampled on the tick that ends offset nulling.
- R4: On the last integration tick the comparator is sampled. While de-integrating, `refNeg` equals that sample (1 = negative reference for a positive input). The latched `signNeg` is its inverse (1 = negative input).
- R5: De-integration (`phRefInt`) ends on the first tick at which the comparator differs from the sampled polarity. If that happens at tick index j (0 = first tick of the phase), the phase lasts j+1 counts, `resultBcd` becomes j and `overRange` clears.
- R6: If no crossing is seen by tick index DEINT_LIMIT-1, the phase ends there (DEINT_LIMIT counts), `overRange` is set and `resultBcd` holds DEINT_LIMIT-1.
- R7: A crossing on the same tick as the limit counts as a valid reading: `resultBcd` is DEINT_LIMIT-1 and `overRange` is 0.
- R8: The settling phase (`phZero`) takes the remaining counts, so every full cycle lasts exactly CYCLE_COUNTS counts (2·CYCLE_COUNTS clocks), whatever the input sign or magnitude.
- R9: `resultValid` is high for one clock, the first clock of the next offset-nulling phase. `resultBcd`, `signNeg` and `overRange` change only as de-integration ends.
- R10: `resultBcd` is packed BCD, with decimal digit i in bits [4i+3:4i] and the least significant digit in bits [3:0].
- R11: A synchronous reset puts the block in offset nulling. It clears the counts, `resultBcd`, `signNeg`, `overRange`, `refNeg` and `resultValid`.
- R12: Exactly one of the four phase outputs is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| integPos | input | 1 | Comparator: integrator output above zero |
| rangeSel | input | 1 | High selects the short integration window |
| phAutoZero | output | 1 | Offset-nulling phase active |
| phIntegrate | output | 1 | Input-integration phase active |
| phRefInt | output | 1 | Reference de-integration phase active |
| phZero | output | 1 | Integrator settling phase active |
| refNeg | output | 1 | Selects the negative reference |
| signNeg | output | 1 | Latched input sign, 1 = negative |
| resultBcd | output | 4·DIGITS (16) | Latched de-integration count, packed BCD |
| resultValid | output | 1 | One-clock pulse at the end of each cycle |
| overRange | output | 1 | Latched over-range flag |

## Verification
The zero crossing and the count limit can both fall on the final de-integration tick. The crossing check then has to win over the cutoff. The bench drives the modelled comparator so that the crossing lands on every tick index from 0 up to two past the limit, under both input polarities and both range settings. Each cycle is judged by the latched count, the over-range flag, the sign, and the measured length of every phase. On the limit tick, only a reading of DEINT_LIMIT-1 with the flag clear passes.

// File: rtl/dsSeqPkg.sv
package dsSeqPkg;

  typedef enum logic [1:0] {
    PH_AZ   = 2'd0,
    PH_INT  = 2'd1,
    PH_REF  = 2'd2,
    PH_ZERO = 2'd3
  } phase_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic clrDe;        // clear de-integration count
    logic incDe;        // advance de-integration count
    logic capSign;      // sample comparator polarity
    logic latchResult;  // copy count/sign/flag to result
    logic overFlag;     // value for over-range on latch
    logic endCycle;     // cycle wraps on this tick
  } seqStrobe_t;

  // decimal to packed BCD, sixteen digits, for constants only
  function automatic logic [63:0] toBcd(input int unsigned value);
    logic [63:0] packed_r;
    int unsigned rem;
    packed_r = '0;
    rem = value;
    for (int i = 0; i < 16; i++) begin
      packed_r[4*i +: 4] = 4'(rem % 10);
      rem = rem / 10;
    end
    return packed_r;
  endfunction

endpackage

// File: rtl/dsSeqDatapath.sv
module dsSeqDatapath
  import dsSeqPkg::*;
#(
  parameter int DIGITS       = 4,
  parameter int AZ_COUNTS    = 1500,
  parameter int INT_LONG     = 2000,
  parameter int INT_SHORT    = 200,
  parameter int DEINT_LIMIT  = 4000,
  parameter int CYCLE_COUNTS = 8000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               integPos,
  input  seqStrobe_t         strobe,
  output logic               tick,
  output logic               azLast,
  output logic               intLastLong,
  output logic               intLastShort,
  output logic               cycleLast,
  output logic               deAtLimit,
  output logic               crossed,
  output logic               refNeg,
  output logic               signNeg,
  output logic [4*DIGITS-1:0] resultBcd,
  output logic               resultValid,
  output logic               overRange
);

  localparam int CNT_W = $clog2(CYCLE_COUNTS);
  localparam int BCD_W = 4 * DIGITS;
  localparam logic [63:0] LIMIT_FULL = toBcd(DEINT_LIMIT - 1);
  localparam logic [BCD_W-1:0] LIMIT_BCD = LIMIT_FULL[BCD_W-1:0];

  logic             divTog;
  logic [CNT_W-1:0] cycleCnt;
  logic [BCD_W-1:0] deCount;
  logic [DIGITS:0]  carry;
  logic             polPos;
  logic             signReg;
  logic             overReg;
  logic             validReg;
  logic [BCD_W-1:0] resultReg;

  // clock halving: a count tick on every second edge
  always_ff @(posedge clk) begin
    if (rst) divTog <= 1'b0;
    else     divTog <= ~divTog;
  end
  assign tick = divTog;

  // position within the conversion cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      cycleCnt <= '0;
    end else if (tick) begin
      if (cycleLast) cycleCnt <= '0;
      else           cycleCnt <= cycleCnt + 1'b1;
    end
  end

  assign azLast       = (cycleCnt == CNT_W'(AZ_COUNTS - 1));
  assign intLastLong  = (cycleCnt == CNT_W'(AZ_COUNTS + INT_LONG - 1));
  assign intLastShort = (cycleCnt == CNT_W'(AZ_COUNTS + INT_SHORT - 1));
  assign cycleLast    = (cycleCnt == CNT_W'(CYCLE_COUNTS - 1));

  // decade chain for the de-integration count
  assign carry[0] = strobe.incDe;
  for (genvar d = 0; d < DIGITS; d++) begin : gDecade
    logic [3:0] digitQ;
    assign carry[d+1] = carry[d] && (digitQ == 4'd9);
    always_ff @(posedge clk) begin
      if (rst || strobe.clrDe)   digitQ <= 4'd0;
      else if (carry[d])         digitQ <= (digitQ == 4'd9) ? 4'd0 : digitQ + 4'd1;
    end
    assign deCount[4*d +: 4] = digitQ;
  end

  assign deAtLimit = (deCount == LIMIT_BCD);

  // polarity seen at the close of integration
  always_ff @(posedge clk) begin
    if (rst)                 polPos <= 1'b0;
    else if (strobe.capSign) polPos <= integPos;
  end
  assign crossed = (integPos != polPos);
  assign refNeg  = polPos;

  // result register
  always_ff @(posedge clk) begin
    if (rst) begin
      resultReg <= '0;
      signReg   <= 1'b0;
      overReg   <= 1'b0;
    end else if (strobe.latchResult) begin
      resultReg <= deCount;
      signReg   <= ~polPos;
      overReg   <= strobe.overFlag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) validReg <= 1'b0;
    else     validReg <= strobe.endCycle;
  end

  assign resultBcd   = resultReg;
  assign signNeg     = signReg;
  assign overRange   = overReg;
  assign resultValid = validReg;

endmodule

// File: rtl/dsSeqControl.sv
module dsSeqControl
  import dsSeqPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rangeSel,
  input  logic       tick,
  input  logic       azLast,
  input  logic       intLastLong,
  input  logic       intLastShort,
  input  logic       cycleLast,
  input  logic       deAtLimit,
  input  logic       crossed,
  output seqStrobe_t strobe,
  output logic [3:0] phaseHot
);

  phase_e state, stateNext;
  logic   shortWin;
  logic   intDone;

  assign intDone = shortWin ? intLastShort : intLastLong;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      PH_AZ: begin
        if (tick && azLast) stateNext = PH_INT;
      end
      PH_INT: begin
        if (tick && intDone) begin
          stateNext      = PH_REF;
          strobe.capSign = 1'b1;
          strobe.clrDe   = 1'b1;
        end
      end
      PH_REF: begin
        if (tick) begin
          if (crossed) begin
            // a crossing outranks the count limit on the same tick
            strobe.latchResult = 1'b1;
            stateNext          = PH_ZERO;
          end else if (deAtLimit) begin
            strobe.latchResult = 1'b1;
            strobe.overFlag    = 1'b1;
            stateNext          = PH_ZERO;
          end else begin
            strobe.incDe = 1'b1;
          end
        end
      end
      PH_ZERO: begin
        if (tick && cycleLast) begin
          strobe.endCycle = 1'b1;
          stateNext       = PH_AZ;
        end
      end
      default: stateNext = PH_AZ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PH_AZ;
    else     state <= stateNext;
  end

  // window choice held for the whole integration phase
  always_ff @(posedge clk) begin
    if (rst)                                     shortWin <= 1'b0;
    else if (state == PH_AZ && tick && azLast)   shortWin <= rangeSel;
  end

  assign phaseHot = {state == PH_ZERO, state == PH_REF,
                     state == PH_INT,  state == PH_AZ};

endmodule

// File: rtl/dualSlopeSequencer.sv
module dualSlopeSequencer
  import dsSeqPkg::*;
#(
  parameter int DIGITS       = 4,
  parameter int AZ_COUNTS    = 1500,
  parameter int INT_LONG     = 2000,
  parameter int INT_SHORT    = 200,
  parameter int DEINT_LIMIT  = 4000,
  parameter int CYCLE_COUNTS = 8000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                integPos,
  input  logic                rangeSel,
  output logic                phAutoZero,
  output logic                phIntegrate,
  output logic                phRefInt,
  output logic                phZero,
  output logic                refNeg,
  output logic                signNeg,
  output logic [4*DIGITS-1:0] resultBcd,
  output logic                resultValid,
  output logic                overRange
);

  seqStrobe_t strobe;
  logic       tick, azLast, intLastLong, intLastShort, cycleLast;
  logic       deAtLimit, crossed;
  logic [3:0] phaseHot;

  dsSeqControl uCtrl (
    .clk         (clk),
    .rst         (rst),
    .rangeSel    (rangeSel),
    .tick        (tick),
    .azLast      (azLast),
    .intLastLong (intLastLong),
    .intLastShort(intLastShort),
    .cycleLast   (cycleLast),
    .deAtLimit   (deAtLimit),
    .crossed     (crossed),
    .strobe      (strobe),
    .phaseHot    (phaseHot)
  );

  dsSeqDatapath #(
    .DIGITS      (DIGITS),
    .AZ_COUNTS   (AZ_COUNTS),
    .INT_LONG    (INT_LONG),
    .INT_SHORT   (INT_SHORT),
    .DEINT_LIMIT (DEINT_LIMIT),
    .CYCLE_COUNTS(CYCLE_COUNTS)
  ) uPath (
    .clk         (clk),
    .rst         (rst),
    .integPos    (integPos),
    .strobe      (strobe),
    .tick        (tick),
    .azLast      (azLast),
    .intLastLong (intLastLong),
    .intLastShort(intLastShort),
    .cycleLast   (cycleLast),
    .deAtLimit   (deAtLimit),
    .crossed     (crossed),
    .refNeg      (refNeg),
    .signNeg     (signNeg),
    .resultBcd   (resultBcd),
    .resultValid (resultValid),
    .overRange   (overRange)
  );

  assign phAutoZero  = phaseHot[0];
  assign phIntegrate = phaseHot[1];
  assign phRefInt    = phaseHot[2];
  assign phZero      = phaseHot[3];

endmodule

// File: rtl/dsSeqChecker.sv
module dsSeqChecker
  import dsSeqPkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int DEINT_LIMIT = 4000
) (
  input logic                clk,
  input logic                rst,
  input logic                phAutoZero,
  input logic                phIntegrate,
  input logic                phRefInt,
  input logic                phZero,
  input logic                signNeg,
  input logic [4*DIGITS-1:0] resultBcd,
  input logic                resultValid,
  input logic                overRange
);

  localparam int BCD_W = 4 * DIGITS;
  localparam logic [63:0] LIMIT_FULL = toBcd(DEINT_LIMIT - 1);
  localparam logic [BCD_W-1:0] LIMIT_BCD = LIMIT_FULL[BCD_W-1:0];

  logic armed;
  int   refClocks;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      refClocks <= 0;
    end else begin
      armed     <= 1'b1;
      refClocks <= phRefInt ? refClocks + 1 : 0;
    end
  end

  assert_one_phase_R12: assert property (@(posedge clk) disable iff (rst || !armed)
    $countones({phAutoZero, phIntegrate, phRefInt, phZero}) == 1);

  assert_az_then_int_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(phAutoZero) |-> phIntegrate);

  assert_int_then_ref_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(phIntegrate) |-> phRefInt);

  assert_ref_then_zero_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(phRefInt) |-> phZero);

  assert_valid_at_wrap_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    resultValid |-> (phAutoZero && $past(phZero)));

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    resultValid |=> !resultValid);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    !phRefInt |=> ($stable(resultBcd) && $stable(overRange) && $stable(signNeg)));

  assert_over_full_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    overRange |-> (resultBcd == LIMIT_BCD));

  assert_ref_bounded_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    phRefInt |-> (refClocks < 2 * DEINT_LIMIT));

endmodule

bind dualSlopeSequencer dsSeqChecker #(
  .DIGITS     (DIGITS),
  .DEINT_LIMIT(DEINT_LIMIT)
) uChk (
  .clk        (clk),
  .rst        (rst),
  .phAutoZero (phAutoZero),
  .phIntegrate(phIntegrate),
  .phRefInt   (phRefInt),
  .phZero     (phZero),
  .signNeg    (signNeg),
  .resultBcd  (resultBcd),
  .resultValid(resultValid),
  .overRange  (overRange)
);

// File: tb/dualSlopeSequencer_test.sv
`timescale 1ns/1ps
module dualSlopeSequencer_test;

  localparam int DIGITS = 2;
  localparam int AZ     = 6;
  localparam int INTL   = 10;
  localparam int INTS   = 1;
  localparam int LIM    = 25;
  localparam int TOTAL  = 50;

  logic       clk = 1'b0;
  logic       rst;
  logic       integPos;
  logic       rangeSel;
  logic       phAutoZero, phIntegrate, phRefInt, phZero;
  logic       refNeg, signNeg, resultValid, overRange;
  logic [7:0] resultBcd;

  int vectors  = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dualSlopeSequencer #(
    .DIGITS(DIGITS), .AZ_COUNTS(AZ), .INT_LONG(INTL), .INT_SHORT(INTS),
    .DEINT_LIMIT(LIM), .CYCLE_COUNTS(TOTAL)
  ) uut (
    .clk(clk), .rst(rst), .integPos(integPos), .rangeSel(rangeSel),
    .phAutoZero(phAutoZero), .phIntegrate(phIntegrate), .phRefInt(phRefInt),
    .phZero(phZero), .refNeg(refNeg), .signNeg(signNeg),
    .resultBcd(resultBcd), .resultValid(resultValid), .overRange(overRange)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int bcd2(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  // one conversion; starts at a negedge inside offset nulling,
  // returns at the negedge where the valid pulse is seen
  task automatic runCycle(input bit rng, input bit pos, input int j);
    int nAz = 0, nInt = 0, nRef = 0, nZero = 0, nAll = 0;
    int refN = 0, badHot = 0, badRef = 0, guard = 0;
    int ni, refLen, expRes;
    bit expOver;
    rangeSel = rng;
    do begin
      nAz   += phAutoZero;
      nInt  += phIntegrate;
      nRef  += phRefInt;
      nZero += phZero;
      nAll++;
      if ((phAutoZero + phIntegrate + phRefInt + phZero) != 1) badHot++;
      if (phRefInt && (refNeg != pos)) badRef++;
      refN = phRefInt ? refN + 1 : 0;
      integPos = (phRefInt && refN >= 2 * j + 1) ? ~pos : pos;
      @(negedge clk);
      guard++;
    end while (!resultValid && guard < 4 * TOTAL);

    ni = rng ? INTS : INTL;
    if (j < LIM) begin
      refLen = j + 1; expRes = j; expOver = 0;
    end else begin
      refLen = LIM; expRes = LIM - 1; expOver = 1;
    end
    check(resultValid, "R9 valid pulse at cycle end", resultValid, 1);
    check(nAz == 2 * AZ, "R1/R2 offset-nulling clocks", nAz, 2 * AZ);
    check(nInt == 2 * ni, "R3 integration clocks", nInt, 2 * ni);
    check(nRef == 2 * refLen, "R5/R6 de-integration clocks", nRef, 2 * refLen);
    check(nZero == 2 * (TOTAL - AZ - ni - refLen), "R8 settling clocks",
          nZero, 2 * (TOTAL - AZ - ni - refLen));
    check(nAll == 2 * TOTAL, "R8 total cycle clocks", nAll, 2 * TOTAL);
    check(badHot == 0, "R12 one-hot phase", badHot, 0);
    check(badRef == 0, "R4 reference polarity", badRef, 0);
    check(signNeg == ~pos, "R4 latched sign", signNeg, ~pos);
    check(overRange == expOver, (j == LIM - 1) ? "R7 over-range at limit crossing"
          : "R6 over-range flag", overRange, expOver);
    check(resultBcd == 8'(bcd2(expRes)), (j == LIM - 1) ? "R7 count at limit crossing"
          : "R5/R10 BCD count", resultBcd, bcd2(expRes));
  endtask

  task automatic checkReset();
    check(phAutoZero && !phIntegrate && !phRefInt && !phZero,
          "R11 reset phase", {phZero, phRefInt, phIntegrate, phAutoZero}, 1);
    check(resultBcd == 0 && !overRange && !signNeg && !refNeg && !resultValid,
          "R11 reset outputs", {resultBcd, overRange, signNeg, refNeg, resultValid}, 0);
  endtask

  initial begin
    rst = 1'b1; integPos = 1'b0; rangeSel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkReset();
    rst = 1'b0;

    for (int rng = 0; rng < 2; rng++)
      for (int pos = 0; pos < 2; pos++)
        for (int j = 0; j <= LIM + 2; j++)
          runCycle(rng[0], pos[0], j);

    // reset in the middle of de-integration
    integPos = 1'b1;
    while (!phRefInt) @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    checkReset();
    rst = 1'b0;
    runCycle(1'b0, 1'b1, 7);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      vectors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
      $finish;
    end
  end

endmodule